// File: doc/BRIEF.md
# ADC Result Register Interface

This block sits between an analog-to-digital converter and a CPU read bus. When the converter signals that a conversion is complete, the block turns the raw signed difference between the two analog inputs into a 10-bit result and keeps it in a result register. The result can be unipolar and clamped, or bipolar in two's complement, and the input pair can optionally be reversed first. The CPU sees the result as two read-only 8-bit registers, a low byte and a high byte. A control input selects whether the 10 bits are packed toward the bottom (right) or the top (left) of the 16-bit pair.

A full 10-bit read must fetch the low byte first and then the high byte. A small state machine guards that pair of reads. It has two states. ST_OPEN is entered at reset and accepts new results. ST_LOCKED holds the register so that both bytes come from the same conversion. The transition T_LOCK (ST_OPEN to ST_LOCKED) fires on a read of the low byte. The transition T_RELEASE (ST_LOCKED to ST_OPEN) fires on a read of the high byte. Any conversion that completes while the register is locked is dropped. When the result is left-aligned and 8 bits of precision are enough, software can read only the high byte, which never locks the register.

The raw input is a signed 12-bit count equal to the positive input minus the negative input. The mode inputs are sampled in the cycle of the completion strobe. The alignment input acts on the read data immediately.

Top module: `adc_result_regs`

## Requirements
- R1: After reset, the result register is zero, so both bytes read 8'h00 in either alignment, and the state machine is in ST_OPEN.
- R2: With left_align=0, the low byte (rd_addr=0) reads result[7:0]. The high byte (rd_addr=1) reads {6'b0, result[9:8]}.
- R3: With left_align=1, the high byte reads result[9:2]. The low byte reads {result[1:0], 6'b0}.
- R4: A cycle with rd_en=1 and rd_addr=0 takes the block to ST_LOCKED. While it is locked, every conv_done is discarded and the result register keeps its value.
- R5: A cycle with rd_en=1 and rd_addr=1 returns the block to ST_OPEN, and the next conv_done is accepted. A high-byte read while in ST_OPEN does not lock.
- R6: In unipolar mode (bipolar=0), the result is the difference clamped to the range 0..1023. A negative difference gives 10'h000, and a difference above 1023 gives 10'h3FF.
- R7: In bipolar mode (bipolar=1), the result is the difference shifted right arithmetically by one bit (halved, rounding toward minus infinity). It is then clamped to the range -512..511 and stored as 10-bit two's complement, so -512 is stored as 10'h200.
- R8: With pol_swap=1, the difference is negated before it is formatted, in both unipolar and bipolar mode.
- R9: A conv_done in the same cycle as a low-byte read is discarded, so the locked pair holds the value that was just read.
- R10: bipolar and pol_swap take effect in the conv_done cycle only. Changing them later does not alter a stored result. left_align affects rd_data at once, without changing the stored result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| conv_raw | input | 12 | Signed difference (positive minus negative input) from the converter |
| bipolar | input | 1 | 1 selects bipolar two's complement format, 0 selects unipolar clamped format |
| pol_swap | input | 1 | 1 negates the difference before formatting |
| left_align | input | 1 | 1 selects left-aligned byte packing, 0 selects right-aligned |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | 1 | Byte select: 0 low byte, 1 high byte |
| rd_data | output | 8 | Selected byte of the result, valid in the same cycle as rd_addr |

## Verification
The hardest case to reach is a conversion that completes in exactly the cycle the low byte is read. This race decides whether the locked pair is coherent. The bench issues conv_done and the low-byte read in the same cycle and then reads the high byte. It also sends conversions while the block is locked, issues a high-byte read with no lock active, and changes the mode inputs after a result has been stored. A behavioural model tracks the lock and the formatted value, and the read data is compared with it on every clock.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
    localparam int RES_W  = 10;
    localparam int RAW_W  = 12;
    localparam int BYTE_W = 8;

    localparam logic ADDR_LO = 1'b0;
    localparam logic ADDR_HI = 1'b1;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_t;
endpackage

// File: rtl/adcr_format.sv
module adcr_format #(
    parameter int RES_W = adcr_pkg::RES_W,
    parameter int RAW_W = adcr_pkg::RAW_W
) (
    input  logic [RAW_W-1:0] raw,
    input  logic             bipolar,
    input  logic             pol_swap,
    output logic [RES_W-1:0] res
);
    localparam int EXT_W  = RAW_W + 1;
    localparam int UMAX_I = (2 ** RES_W) - 1;
    localparam int BMAX_I = (2 ** (RES_W - 1)) - 1;
    localparam int BMIN_I = -(2 ** (RES_W - 1));
    localparam logic signed [EXT_W-1:0] UMAX = EXT_W'(UMAX_I);
    localparam logic signed [EXT_W-1:0] BMAX = EXT_W'(BMAX_I);
    localparam logic signed [EXT_W-1:0] BMIN = EXT_W'(BMIN_I);

    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] diff;
    logic signed [EXT_W-1:0] half;
    logic signed [EXT_W-1:0] clamped;

    always_comb begin
        ext  = {raw[RAW_W-1], raw};
        diff = pol_swap ? -ext : ext;
        half = diff >>> 1;
        if (!bipolar) begin
            if (diff < 0)          clamped = '0;
            else if (diff > UMAX)  clamped = UMAX;
            else                   clamped = diff;
        end else begin
            if (half < BMIN)       clamped = BMIN;
            else if (half > BMAX)  clamped = BMAX;
            else                   clamped = half;
        end
        res = clamped[RES_W-1:0];
    end
endmodule

// File: rtl/adcr_align.sv
module adcr_align #(
    parameter int RES_W  = adcr_pkg::RES_W,
    parameter int BYTE_W = adcr_pkg::BYTE_W
) (
    input  logic [RES_W-1:0]  res,
    input  logic              left_align,
    input  logic              sel_hi,
    output logic [BYTE_W-1:0] byte_out
);
    localparam int HI_BITS = RES_W - BYTE_W;
    localparam int PAD     = BYTE_W - HI_BITS;

    logic [BYTE_W-1:0] lo_byte;
    logic [BYTE_W-1:0] hi_byte;

    always_comb begin
        if (left_align) begin
            hi_byte = res[RES_W-1:HI_BITS];
            lo_byte = {res[HI_BITS-1:0], {PAD{1'b0}}};
        end else begin
            hi_byte = {{PAD{1'b0}}, res[RES_W-1:BYTE_W]};
            lo_byte = res[BYTE_W-1:0];
        end
        byte_out = sel_hi ? hi_byte : lo_byte;
    end
endmodule

// File: rtl/adcr_lock_fsm.sv
module adcr_lock_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic rd_addr,
    output logic accept
);
    import adcr_pkg::*;

    lock_state_t state_q;
    lock_state_t state_d;
    logic        rd_lo;
    logic        rd_hi;

    assign rd_lo = rd_en && (rd_addr == ADDR_LO);
    assign rd_hi = rd_en && (rd_addr == ADDR_HI);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                accept = !rd_lo;
                if (rd_lo) state_d = ST_LOCKED;      // T_LOCK
            end
            ST_LOCKED: begin
                accept = 1'b0;
                if (rd_hi) state_d = ST_RELEASE_TARGET();
            end
            default: state_d = ST_OPEN;
        endcase
    end

    function automatic lock_state_t ST_RELEASE_TARGET();
        return ST_OPEN;                               // T_RELEASE
    endfunction

    p_lock_on_low_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (state_q == ST_LOCKED));

    p_release_on_high_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && rd_hi) |=> (state_q == ST_OPEN));

    p_open_high_stays_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && !rd_lo) |=> (state_q == ST_OPEN));

    p_no_accept_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |-> !accept);
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
    parameter int RES_W  = adcr_pkg::RES_W,
    parameter int RAW_W  = adcr_pkg::RAW_W,
    parameter int BYTE_W = adcr_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RAW_W-1:0]  conv_raw,
    input  logic              bipolar,
    input  logic              pol_swap,
    input  logic              left_align,
    input  logic              rd_en,
    input  logic              rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int PAD = BYTE_W - (RES_W - BYTE_W);

    logic [RES_W-1:0] fmt_res;
    logic [RES_W-1:0] res_q;
    logic             accept;

    adcr_format #(.RES_W(RES_W), .RAW_W(RAW_W)) u_format (
        .raw      (conv_raw),
        .bipolar  (bipolar),
        .pol_swap (pol_swap),
        .res      (fmt_res)
    );

    adcr_lock_fsm u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .accept  (accept)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   res_q <= '0;
        else if (conv_done && accept) res_q <= fmt_res;
    end

    adcr_align #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_align (
        .res        (res_q),
        .left_align (left_align),
        .sel_hi     (rd_addr),
        .byte_out   (rd_data)
    );

    p_hold_when_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(res_q));

    p_left_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (left_align && rd_addr == adcr_pkg::ADDR_LO) |-> (rd_data[PAD-1:0] == '0));

    p_right_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!left_align && rd_addr == adcr_pkg::ADDR_HI) |-> (rd_data[BYTE_W-1:BYTE_W-PAD] == '0));

    p_uni_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && accept && !bipolar && !pol_swap && conv_raw[RAW_W-1])
        |=> (res_q == '0));
endmodule

// File: tb/adc_result_regs_bench.sv
module adc_result_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_raw = '0;
    logic        bipolar = 1'b0;
    logic        pol_swap = 1'b0;
    logic        left_align = 1'b0;
    logic        rd_en = 1'b0;
    logic        rd_addr = 1'b0;
    logic [7:0]  rd_data;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    int ref_res = 0;
    bit ref_lock = 0;

    always #5 clk = ~clk;

    adc_result_regs u_adc_result_regs (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_raw(conv_raw),
        .bipolar(bipolar), .pol_swap(pol_swap), .left_align(left_align),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int fmt(int raw, bit bip, bit sw);
        int d;
        int h;
        d = sw ? -raw : raw;
        if (!bip) begin
            if (d < 0) return 0;
            if (d > 1023) return 1023;
            return d;
        end
        h = d >>> 1;
        if (h < -512) h = -512;
        if (h > 511) h = 511;
        return h & 32'h3FF;
    endfunction

    function automatic int exp_byte(int r, bit la, bit hi);
        if (la) return hi ? ((r >> 2) & 8'hFF) : ((r & 3) << 6);
        return hi ? ((r >> 8) & 3) : (r & 8'hFF);
    endfunction

    // one clock: drive at negedge, compare before posedge, then advance the model
    task automatic step(string tag, bit cd, int raw, bit bip, bit sw, bit la, bit re, bit addr);
        int e;
        bit acc;
        conv_done = cd; conv_raw = raw[11:0]; bipolar = bip; pol_swap = sw;
        left_align = la; rd_en = re; rd_addr = addr;
        #1;
        e = exp_byte(ref_res, la, addr);
        compared++;
        if (rd_data !== e[7:0]) begin
            mismatched++;
            $display("FAIL %s: rd_data=%h expected %h", tag, rd_data, e[7:0]);
        end
        acc = cd && !ref_lock && !(re && !addr);
        if (acc) ref_res = fmt(raw, bip, sw);
        if (re && !addr) ref_lock = 1;
        else if (re && addr) ref_lock = 0;
        @(negedge clk);
    endtask

    task automatic conv(string tag, int raw, bit bip, bit sw);
        step(tag, 1, raw, bip, sw, left_align, 0, 0);
    endtask

    task automatic rd(string tag, bit la, bit addr);
        step(tag, 0, 0, bipolar, pol_swap, la, 1, addr);
    endtask

    task automatic peek(string tag, bit la, bit addr);
        step(tag, 0, 0, bipolar, pol_swap, la, 0, addr);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset state, both alignments and bytes
        peek("R1", 0, 0); peek("R1", 0, 1); peek("R1", 1, 0); peek("R1", 1, 1);
        rst_n = 1'b1;
        @(negedge clk);
        peek("R1", 0, 1);

        // R2: right alignment, full low-then-high read
        conv("R2", 12'h2A5, 0, 0);
        rd("R2", 0, 0); rd("R2", 0, 1);

        // R3: left alignment, high-only read does not lock (R5)
        conv("R3", 12'h1E7, 0, 0);
        peek("R3", 1, 0);
        rd("R3", 1, 1);
        conv("R5", 12'h0C3, 0, 0);
        rd("R5", 1, 1); peek("R5", 0, 0);

        // R4: lock holds across incoming conversions
        rd("R4", 0, 0);
        conv("R4", 12'h155, 0, 0);
        conv("R4", 12'h3FF, 0, 0);
        peek("R4", 0, 0); peek("R4", 1, 1);
        rd("R4", 0, 0);
        conv("R4", 12'h011, 0, 0);
        rd("R4", 0, 1);
        // R5: after release the next conversion lands
        conv("R5", 12'h2F0, 0, 0);
        peek("R5", 0, 0); peek("R5", 0, 1);

        // R6: unipolar clamping
        conv("R6", -5, 0, 0);   peek("R6", 0, 0); peek("R6", 0, 1);
        conv("R6", 1500, 0, 0); peek("R6", 0, 0); peek("R6", 0, 1);
        conv("R6", 1023, 0, 0); peek("R6", 1, 1);
        conv("R6", -2048, 0, 0); peek("R6", 0, 0);

        // R7: bipolar two's complement
        conv("R7", -6, 1, 0);    peek("R7", 0, 0); peek("R7", 0, 1);
        conv("R7", 2000, 1, 0);  peek("R7", 0, 0); peek("R7", 0, 1);
        conv("R7", -2048, 1, 0); peek("R7", 0, 0); peek("R7", 0, 1);
        conv("R7", 7, 1, 0);     peek("R7", 0, 0);
        conv("R7", -1, 1, 0);    peek("R7", 0, 0); peek("R7", 1, 1);

        // R8: polarity swap
        conv("R8", -300, 0, 1);  peek("R8", 0, 0); peek("R8", 0, 1);
        conv("R8", 300, 0, 1);   peek("R8", 0, 0);
        conv("R8", 10, 1, 1);    peek("R8", 0, 0); peek("R8", 0, 1);
        conv("R8", -2048, 0, 1); peek("R8", 0, 1);

        // R9: conversion in the same cycle as the low read is dropped
        conv("R9", 12'h0AB, 0, 0);
        step("R9", 1, 12'h354, 0, 0, 0, 1, 0);
        peek("R9", 0, 0);
        rd("R9", 0, 1);
        peek("R9", 0, 0);

        // R10: mode sampled at conv_done; alignment acts on reads only
        conv("R10", -40, 1, 0);
        step("R10", 0, 0, 0, 1, 0, 0, 0);
        peek("R10", 0, 1); peek("R10", 1, 1); peek("R10", 1, 0); peek("R10", 0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule